// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sequences the operating modes of a small dual-clock microcontroller. There are two running modes, one on the fast oscillator (NORMAL2) and one on the slow oscillator (SLOW1). Software can move from either running mode into one of three sleep states or into full STOP. Each mode drives its own set of clock gate enables: for the CPU, the watchdog, the time-base timer, the peripherals and the prescaler/divider chain. The block also enables the two oscillators. A wake line returns a sleep state to a fixed running mode.

STOP is different. It halts everything and records which running mode it was entered from. On wake it first runs a programmable warm-up down-counter. It resumes the recorded mode only when that count has expired and the oscillator reports that it is stable.

Mode requests arrive on a valid/ready port. The sequencer accepts a request only while the CPU is running, that is in NORMAL2 or SLOW1. In every other state, warm-up included, `req_ready` is low. A requester must then hold `req_valid` and `req_mode` steady until the request is taken. The wake, oscillator and enable pins are plain level signals.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the mode is NORMAL2, `req_ready` is 1, and all of the following are 1: `cpu_ce`, `wdt_ce`, `tbt_ce`, `periph_ce`, `presc_ce`, `hf_osc_en` and `lf_osc_en`.
- R2: `mode_o` uses these codes: NORMAL2=0, SLOW1=1, IDLE2=2, SLEEP1=3, SLEEP0=4, STOP=5. It shows 5 during warm-up too. An accepted request changes `mode_o` at the next clock edge. Legal targets from NORMAL2 are 1, 2 and 5. Legal targets from SLOW1 are 0, 3, 4 and 5. Any other accepted request leaves the mode unchanged.
- R3: `req_ready` is 1 only in NORMAL2 and SLOW1. A request presented during STOP or warm-up waits and is accepted once the resumed mode is active.
- R4: In NORMAL2, all five clock enables are 1. In SLOW1, `presc_ce` is 0 and `hf_osc_en` is 0, while the other enables are 1. In IDLE2, `cpu_ce` and `wdt_ce` are 0, while peripherals, timer and prescaler stay enabled.
- R5: In SLEEP1, `cpu_ce`, `wdt_ce` and `presc_ce` are 0, and `periph_ce` and `tbt_ce` pulse on one cycle in every four. In SLEEP0, only `tbt_ce` pulses, on one cycle in every four.
- R6: In STOP, every clock enable and both oscillator enables are 0. The mode stays STOP until a wake line is raised.
- R7: A wake in IDLE2 returns to NORMAL2. A wake in SLEEP1 or SLEEP0 returns to SLOW1. In both cases the change happens at the next edge.
- R8: A wake in STOP loads `warm_cycles` into the warm-up counter. With the oscillator stable, the mode leaves STOP `warm_cycles`+1 edges after the wake edge.
- R9: At the end of warm-up the resume is held off for as long as `osc_stable` is 0.
- R10: Resume from STOP restores the running mode that was active when STOP was entered.
- R11: Wake lines have no effect in NORMAL2 or SLOW1.
- R12: `resume_o` is high for exactly one cycle: the cycle just before the mode leaves STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Mode request valid |
| req_ready | output | 1 | Mode request can be accepted |
| req_mode | input | 3 | Requested target mode code |
| wake_i | input | NUM_WAKE | Wake/release request lines |
| osc_stable | input | 1 | Oscillator has settled |
| warm_cycles | input | WARM_W | Warm-up count loaded on STOP wake |
| mode_o | output | 3 | Current mode code |
| resume_o | output | 1 | One-cycle strobe ending warm-up |
| cpu_ce | output | 1 | CPU clock enable |
| wdt_ce | output | 1 | Watchdog clock enable |
| tbt_ce | output | 1 | Time-base-timer clock enable |
| periph_ce | output | 1 | Peripheral clock enable |
| presc_ce | output | 1 | Prescaler/divider output enable |
| hf_osc_en | output | 1 | High-frequency oscillator enable |
| lf_osc_en | output | 1 | Low-frequency oscillator enable |

## Verification
The bench goes first after the return paths out of STOP.

- It enters STOP from both running modes. A design that returned to a fixed mode, or lost the recorded mode, would come back in the wrong mode.
- It measures warm-up to the exact edge. An off-by-one counter would show STOP one cycle too long or too short.
- It holds the oscillator unstable at the end of warm-up. It also presents a request during warm-up, which must wait rather than be taken or dropped.

It also covers the smaller cases. It sends illegal targets and wake pulses while running, which must change nothing. It counts the quarter-rate enable pulses in both sleep states, so a design that left the peripheral clock free-running, or gated the timer in SLEEP0, shows the wrong count.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    MD_NORMAL2 = 3'd0,
    MD_SLOW1   = 3'd1,
    MD_IDLE2   = 3'd2,
    MD_SLEEP1  = 3'd3,
    MD_SLEEP0  = 3'd4,
    MD_STOP    = 3'd5,
    MD_WARM    = 3'd6
  } mode_e;

  function automatic logic legal_move(input mode_e from, input mode_e to);
    logic ok;
    ok = 1'b0;
    if (from == MD_NORMAL2)
      ok = (to == MD_SLOW1) || (to == MD_IDLE2) || (to == MD_STOP);
    else if (from == MD_SLOW1)
      ok = (to == MD_NORMAL2) || (to == MD_SLEEP1) ||
           (to == MD_SLEEP0) || (to == MD_STOP);
    return ok;
  endfunction

  function automatic logic is_running(input mode_e m);
    return (m == MD_NORMAL2) || (m == MD_SLOW1);
  endfunction

endpackage

// File: rtl/pwr_warmup_cnt.sv
module pwr_warmup_cnt #(
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [WW-1:0] load_val,
  input  logic          run,
  output logic          zero
);
  localparam logic [WW-1:0] ONE = {{(WW-1){1'b0}}, 1'b1};

  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (run && (cnt_q != '0))
      cnt_q <= cnt_q - ONE;
  end

  assign zero = (cnt_q == '0);

  AST_CNT_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE)); // R8

  AST_CNT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val))); // R8

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_fire,
  input  logic [2:0] req_mode,
  input  logic       wake_any,
  input  logic       osc_stable,
  input  logic       cnt_zero,
  output mode_e      state_o,
  output mode_e      saved_o,
  output logic       load_o,
  output logic       resume_o
);
  mode_e state_q, state_d, saved_q, saved_d;
  mode_e target;

  assign target   = mode_e'(req_mode);
  assign resume_o = (state_q == MD_WARM) && cnt_zero && osc_stable;

  always_comb begin
    state_d = state_q;
    saved_d = saved_q;
    load_o  = 1'b0;
    unique case (state_q)
      MD_NORMAL2, MD_SLOW1: begin
        if (req_fire && legal_move(state_q, target)) begin
          state_d = target;
          if (target == MD_STOP) saved_d = state_q;
        end
      end
      MD_IDLE2:            if (wake_any) state_d = MD_NORMAL2;
      MD_SLEEP1, MD_SLEEP0: if (wake_any) state_d = MD_SLOW1;
      MD_STOP: begin
        if (wake_any) begin
          state_d = MD_WARM;
          load_o  = 1'b1;
        end
      end
      MD_WARM:             if (resume_o) state_d = saved_q;
      default:             state_d = MD_NORMAL2;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MD_NORMAL2;
      saved_q <= MD_NORMAL2;
    end else begin
      state_q <= state_d;
      saved_q <= saved_d;
    end
  end

  assign state_o = state_q;
  assign saved_o = saved_q;

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MD_STOP && !wake_any) |=> (state_q == MD_STOP)); // R6

  AST_WAKE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (is_running(state_q) && !req_fire) |=> $stable(state_q)); // R11

  AST_RESUME_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |=> (state_q == $past(saved_q))); // R10

  AST_OSC_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MD_WARM && !osc_stable) |=> (state_q == MD_WARM)); // R9

  AST_SAVED_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MD_STOP) |-> is_running(saved_q)); // R10

endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate
  import pwr_mode_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e state,
  input  mode_e saved,
  output logic  cpu_ce,
  output logic  wdt_ce,
  output logic  tbt_ce,
  output logic  periph_ce,
  output logic  presc_ce,
  output logic  hf_osc_en,
  output logic  lf_osc_en
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);
  localparam logic [DW-1:0] ONE  = {{(DW-1){1'b0}}, 1'b1};

  logic          asleep;
  logic [DW-1:0] div_q;
  logic          qtick;

  assign asleep = (state == MD_SLEEP1) || (state == MD_SLEEP0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                div_q <= '0;
    else if (!asleep)          div_q <= '0;
    else if (div_q == LAST)    div_q <= '0;
    else                       div_q <= div_q + ONE;
  end

  assign qtick = asleep && (div_q == LAST);

  always_comb begin
    cpu_ce = 1'b0; wdt_ce = 1'b0; tbt_ce = 1'b0;
    periph_ce = 1'b0; presc_ce = 1'b0;
    unique case (state)
      MD_NORMAL2: begin
        cpu_ce = 1'b1; wdt_ce = 1'b1; tbt_ce = 1'b1;
        periph_ce = 1'b1; presc_ce = 1'b1;
      end
      MD_SLOW1: begin
        cpu_ce = 1'b1; wdt_ce = 1'b1; tbt_ce = 1'b1; periph_ce = 1'b1;
      end
      MD_IDLE2: begin
        tbt_ce = 1'b1; periph_ce = 1'b1; presc_ce = 1'b1;
      end
      MD_SLEEP1: begin
        tbt_ce = qtick; periph_ce = qtick;
      end
      MD_SLEEP0: tbt_ce = qtick;
      default: ;
    endcase
  end

  assign hf_osc_en = (state == MD_NORMAL2) || (state == MD_IDLE2) ||
                     ((state == MD_WARM) && (saved == MD_NORMAL2));
  assign lf_osc_en = (state != MD_STOP);

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    qtick |=> !qtick); // R5

  AST_SLEEP_CPU_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (!cpu_ce && !wdt_ce && !presc_ce)); // R5

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int NUM_WAKE = 4,
  parameter int WARM_W   = 16,
  parameter int DIV      = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [2:0]          req_mode,
  input  logic [NUM_WAKE-1:0] wake_i,
  input  logic                osc_stable,
  input  logic [WARM_W-1:0]   warm_cycles,
  output logic [2:0]          mode_o,
  output logic                resume_o,
  output logic                cpu_ce,
  output logic                wdt_ce,
  output logic                tbt_ce,
  output logic                periph_ce,
  output logic                presc_ce,
  output logic                hf_osc_en,
  output logic                lf_osc_en
);
  mode_e state, saved;
  logic  wake_any, req_fire, cnt_load, cnt_zero;

  assign wake_any  = |wake_i;
  assign req_ready = is_running(state);
  assign req_fire  = req_valid && req_ready;
  assign mode_o    = (state == MD_WARM) ? 3'(MD_STOP) : 3'(state);

  pwr_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_fire(req_fire), .req_mode(req_mode),
    .wake_any(wake_any), .osc_stable(osc_stable), .cnt_zero(cnt_zero),
    .state_o(state), .saved_o(saved), .load_o(cnt_load), .resume_o(resume_o)
  );

  pwr_warmup_cnt #(.WW(WARM_W)) u_warm (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(warm_cycles),
    .run(state == MD_WARM), .zero(cnt_zero)
  );

  pwr_clk_gate #(.DIV(DIV)) u_gate (
    .clk(clk), .rst_n(rst_n), .state(state), .saved(saved),
    .cpu_ce(cpu_ce), .wdt_ce(wdt_ce), .tbt_ce(tbt_ce), .periph_ce(periph_ce),
    .presc_ce(presc_ce), .hf_osc_en(hf_osc_en), .lf_osc_en(lf_osc_en)
  );

  AST_RESUME_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |=> !resume_o); // R12

  AST_STOP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd5) |-> !(cpu_ce || wdt_ce || tbt_ce || periph_ce || presc_ce)); // R6

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd5) |-> !req_ready); // R3

endmodule

// File: tb/tb_pwr_mode_seq.sv
module tb_pwr_mode_seq;
  localparam int NW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_mode = 3'd0;
  logic [NW-1:0] wake_i = '0;
  logic osc_stable = 1'b1;
  logic [15:0] warm_cycles = 16'd0;
  logic [2:0] mode_o;
  logic resume_o, cpu_ce, wdt_ce, tbt_ce, periph_ce, presc_ce, hf_osc_en, lf_osc_en;

  int n_chk = 0, n_fail = 0;
  logic [2:0] exp_q[$];
  logic [2:0] last_mode = 3'd0;
  bit done = 0;

  always #5 clk = ~clk;

  pwr_mode_seq #(.NUM_WAKE(NW), .WARM_W(16), .DIV(4)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .wake_i(wake_i), .osc_stable(osc_stable),
    .warm_cycles(warm_cycles), .mode_o(mode_o), .resume_o(resume_o),
    .cpu_ce(cpu_ce), .wdt_ce(wdt_ce), .tbt_ce(tbt_ce), .periph_ce(periph_ce),
    .presc_ce(presc_ce), .hf_osc_en(hf_osc_en), .lf_osc_en(lf_osc_en)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: every mode change is popped from the scoreboard (R2)
  always @(negedge clk) begin
    if (rst_n && !done && mode_o !== last_mode) begin
      if (exp_q.size() == 0) check("R2 unexpected mode change", int'(mode_o), int'(last_mode));
      else check("R2 scoreboard mode", int'(mode_o), int'(exp_q.pop_front()));
      last_mode = mode_o;
    end
  end

  task automatic do_req(input logic [2:0] m);
    @(negedge clk); req_valid = 1'b1; req_mode = m;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic wake_pulse(input int line);
    @(negedge clk); wake_i[line] = 1'b1;
    @(negedge clk); wake_i = '0;
  endtask

  task automatic count_ticks(output int np, output int nt, output int nc);
    np = 0; nt = 0; nc = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      np += int'(periph_ce); nt += int'(tbt_ce); nc += int'(cpu_ce | wdt_ce | presc_ce);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int np, nt, nc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mode", mode_o, 0);
    check("R1 ready", req_ready, 1);
    check("R1 enables", {cpu_ce, wdt_ce, tbt_ce, periph_ce, presc_ce, hf_osc_en, lf_osc_en}, 7'h7F);

    wake_pulse(2); @(negedge clk);
    check("R11 wake in NORMAL2", mode_o, 0);

    do_req(3'd4);
    check("R2 illegal NORMAL2->SLEEP0", mode_o, 0);

    exp_q.push_back(3'd1); do_req(3'd1);
    check("R4 SLOW1 enables", {cpu_ce, wdt_ce, tbt_ce, periph_ce, presc_ce, hf_osc_en}, 6'b111100);
    do_req(3'd2);
    check("R2 illegal SLOW1->IDLE2", mode_o, 1);
    wake_pulse(0); @(negedge clk);
    check("R11 wake in SLOW1", mode_o, 1);

    exp_q.push_back(3'd3); do_req(3'd3);
    check("R3 ready low in SLEEP1", req_ready, 0);
    count_ticks(np, nt, nc);
    check("R5 SLEEP1 periph ticks", np, 2);
    check("R5 SLEEP1 tbt ticks", nt, 2);
    check("R5 SLEEP1 cpu/wdt/presc", nc, 0);
    exp_q.push_back(3'd1); wake_pulse(1);
    check("R7 SLEEP1->SLOW1", mode_o, 1);

    exp_q.push_back(3'd4); do_req(3'd4);
    count_ticks(np, nt, nc);
    check("R5 SLEEP0 periph ticks", np, 0);
    check("R5 SLEEP0 tbt ticks", nt, 2);
    exp_q.push_back(3'd1); wake_pulse(3);
    check("R7 SLEEP0->SLOW1", mode_o, 1);

    exp_q.push_back(3'd0); do_req(3'd0);
    check("R2 SLOW1->NORMAL2", mode_o, 0);
    exp_q.push_back(3'd2); do_req(3'd2);
    check("R4 IDLE2 enables", {cpu_ce, wdt_ce, tbt_ce, periph_ce, presc_ce}, 5'b00111);
    exp_q.push_back(3'd0); wake_pulse(0);
    check("R7 IDLE2->NORMAL2", mode_o, 0);

    // STOP from NORMAL2, warm-up of 5, request held off during warm-up
    warm_cycles = 16'd5; osc_stable = 1'b1;
    exp_q.push_back(3'd5); exp_q.push_back(3'd0); exp_q.push_back(3'd1);
    do_req(3'd5);
    check("R6 STOP enables", {cpu_ce, wdt_ce, tbt_ce, periph_ce, presc_ce, hf_osc_en, lf_osc_en}, 0);
    check("R3 ready low in STOP", req_ready, 0);
    repeat (4) @(negedge clk);
    check("R6 STOP held", mode_o, 5);
    wake_pulse(1);
    req_valid = 1'b1; req_mode = 3'd1;
    for (int i = 1; i < 5; i++) begin
      @(negedge clk);
      check("R3 ready low in warm-up", req_ready, 0);
      check("R12 no early resume", resume_o, 0);
    end
    @(negedge clk);
    check("R8 still STOP at N", mode_o, 5);
    check("R12 resume strobe", resume_o, 1);
    @(negedge clk);
    check("R8 left STOP at N+1", mode_o, 0);
    check("R10 back to NORMAL2", mode_o, 0);
    check("R12 strobe single", resume_o, 0);
    check("R3 ready after resume", req_ready, 1);
    @(negedge clk); req_valid = 1'b0;
    check("R3 held request taken", mode_o, 1);

    // STOP from SLOW1, zero warm-up, oscillator not yet stable
    warm_cycles = 16'd0; osc_stable = 1'b0;
    exp_q.push_back(3'd5); exp_q.push_back(3'd1);
    do_req(3'd5);
    wake_pulse(2);
    repeat (6) @(negedge clk);
    check("R9 held for oscillator", mode_o, 5);
    check("R9 no strobe while unstable", resume_o, 0);
    check("R10 lf osc on, hf off in warm-up", {lf_osc_en, hf_osc_en}, 2'b10);
    osc_stable = 1'b1;
    @(negedge clk);
    check("R10 back to SLOW1", mode_o, 1);
    repeat (2) @(negedge clk);
    check("R2 scoreboard drained", exp_q.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule